// File: doc/BRIEF.md
# Threshold-Driven FIFO Transfer Request with Hysteresis

This block holds a 16-byte FIFO between a byte-wide device stream and a host that moves data two bytes at a time through a 16-bit buffer port. It drives an active-low request line that can feed a DMA engine or an interrupt input. A direction input chooses the mode. In receive mode the device fills the FIFO and the host drains it. In transmit mode the host fills it and the device drains it.

The request starts when the fill level (receive) or the free space (transmit) reaches a programmable threshold. It then stays active until fewer than two bytes are left to move: fewer than two bytes held in receive, or fewer than two free slots in transmit. Once it has been released this way, it stays inactive until software clears and sets the enable bit again. Software does this after moving data by programmed reads and writes.

The device side is a valid/ready byte stream. A byte moves on a clock edge where both valid and ready are high. `dev_in_ready` is low when the FIFO is full or the mode is transmit. `dev_out_valid` is low when the FIFO is empty or the mode is receive. While valid is high and ready is low, the offered data must not change. The host side is register-style and has no back-pressure: a strobe of one cycle is one access, and an access that cannot complete is flagged instead of stalled.

Top module: `pp_fifo_dreq`

## Requirements
- R1: After reset: `dreq_n` is 1, `fill_level` is 0, `underflow` and `overflow` are 0, the threshold register is 0, and the mode is receive.
- R2: A cycle with `thr_load` high stores `thr_value` in the threshold register. While the stored value is 0, the request never asserts.
- R3: Receive mode (`cfg_dir`=0). Let T be the threshold. If the request is armed and the fill level is at least max(T,2) at a clock edge, `dreq_n` is 0 after that edge. It stays 0 while the level is 2 or more, and it returns to 1 after the first edge at which the level is below 2.
- R4: Transmit mode (`cfg_dir`=1). The same rule applies to the free space, which is 16 minus the fill level: the request asserts at a free space of at least max(T,2) and releases when the free space is below 2.
- R5: After a release under R3 or R4, the request stays inactive whatever the fill level, until `cfg_dma_en` is driven 0 and then 1 again.
- R6: While `cfg_dma_en` is 0, `dreq_n` is 1 in the same cycle, with no clock edge needed, and the request is cleared.
- R7: A change of `cfg_dir` while enabled clears the request at the next edge and disarms it until the enable is toggled.
- R8: A host read in receive mode returns the oldest byte in `host_rdata[7:0]` and the next byte in `[15:8]`. It removes both bytes. The data is valid from the edge that samples `host_rd`.
- R9: A receive read that finds fewer than 2 bytes returns the bytes that exist, with the missing upper bytes set to 0. It removes only those bytes and sets the sticky `underflow` flag.
- R10: A transmit host write stores `host_wdata[7:0]` first and then `[15:8]`. If fewer than 2 slots are free, the write is dropped and the sticky `overflow` flag is set.
- R11: Device stream. In receive mode a byte is taken on `dev_in_valid && dev_in_ready`, and ready is 0 when the FIFO is full. In transmit mode `dev_out_data` shows the oldest byte while `dev_out_valid` is 1, and `dev_out_valid` is 0 when the FIFO is empty.
- R12: Host accesses in the wrong mode have no effect. A read in transmit mode returns 0 and removes nothing. A write in receive mode stores nothing. The device stream is idle in the unused direction.
- R13: A cycle with `err_clr` high clears `underflow` and `overflow`. Neither flag falls at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir | input | 1 | Mode: 0 receive, 1 transmit |
| cfg_dma_en | input | 1 | Request enable; driving it low and then high again re-arms the request |
| thr_load | input | 1 | Loads `thr_value` into the threshold register |
| thr_value | input | 5 | Threshold in bytes (0 keeps the request off) |
| err_clr | input | 1 | Clears the underflow and overflow flags |
| dev_in_valid | input | 1 | Device byte offered (receive) |
| dev_in_ready | output | 1 | FIFO accepts a device byte |
| dev_in_data | input | 8 | Device byte |
| dev_out_valid | output | 1 | FIFO byte offered to the device (transmit) |
| dev_out_ready | input | 1 | Device takes the byte |
| dev_out_data | output | 8 | Oldest FIFO byte |
| host_rd | input | 1 | Host 16-bit buffer read strobe |
| host_wr | input | 1 | Host 16-bit buffer write strobe |
| host_wdata | input | 16 | Host write word, lower byte first |
| host_rdata | output | 16 | Host read word, valid after the read edge |
| fill_level | output | 5 | Bytes held, 0 to 16 |
| underflow | output | 1 | Sticky: short receive read |
| overflow | output | 1 | Sticky: dropped transmit write |
| dreq_n | output | 1 | Transfer request, active low |

## Verification
The threshold is swept over every value from 0 to 16 in both modes. For each value the FIFO is filled one byte at a time in receive mode, or one word at a time in transmit mode, and then drained. This separates the assert point (threshold, with its floor of 2) from the release point (fewer than 2 bytes to move), and it shows that the request holds through the whole band between them. After each drain the FIFO is refilled with the enable left high, and then again after an enable toggle; the pair of results separates a missing disarm from a missing re-arm. Directed patterns cover the cases the sweep cannot reach: short reads with 1 and 0 bytes left, a write into a full FIFO, accesses in the wrong mode, a mode change while the request is active, and dropping the enable while the request is active.

// File: rtl/pp_dreq_pkg.sv
package pp_dreq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo
  import pp_dreq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] push_cnt,
  input  byte_t         push_data [LANES],
  input  logic [CW-1:0] pop_cnt,
  output byte_t         peek [LANES],
  output logic [CW-1:0] level
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_cnt);
      rd_ptr <= rd_ptr + AW'(pop_cnt);
      level  <= level + push_cnt - pop_cnt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (CW'(i) < push_cnt) mem[wr_ptr + AW'(i)] <= push_data[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek[g] = mem[rd_ptr + AW'(g)];
  end

  // R11
  fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) + int'(push_cnt)) <= DEPTH);
  // R9
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_cnt <= level);
endmodule

// File: rtl/pp_host_port.sv
module pp_host_port
  import pp_dreq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = BYTE_W * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_tx,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  input  logic          err_clr,
  input  logic [CW-1:0] level,
  input  byte_t         peek [LANES],
  output logic [CW-1:0] pop_cnt,
  output logic [CW-1:0] push_cnt,
  output byte_t         push_data [LANES],
  output logic [HW-1:0] host_rdata,
  output logic          underflow,
  output logic          overflow
);
  logic [CW-1:0] avail;
  logic [CW-1:0] free_slots;
  logic          rd_go;
  logic          wr_try;
  logic          wr_go;
  logic          short_rd;
  logic          blocked_wr;
  logic [HW-1:0] rd_next;

  assign avail      = (level >= CW'(LANES)) ? CW'(LANES) : level;
  assign free_slots = CW'(DEPTH) - level;
  assign rd_go      = host_rd && !dir_tx;
  assign wr_try     = host_wr && dir_tx;
  assign short_rd   = rd_go && (level < CW'(LANES));
  assign blocked_wr = wr_try && (free_slots < CW'(LANES));
  assign wr_go      = wr_try && !blocked_wr;
  assign pop_cnt    = rd_go ? avail : '0;
  assign push_cnt   = wr_go ? CW'(LANES) : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign push_data[g] = host_wdata[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_go && (CW'(i) < avail)) rd_next[i*BYTE_W +: BYTE_W] = peek[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rd_next;
      if (short_rd)     underflow <= 1'b1;
      else if (err_clr) underflow <= 1'b0;
      if (blocked_wr)   overflow <= 1'b1;
      else if (err_clr) overflow <= 1'b0;
    end
  end

  // R10
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dir_tx && (int'(level) > DEPTH - LANES)) |-> (push_cnt == '0));
  // R12
  wrong_dir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |-> (pop_cnt == '0));
  // R13
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(underflow) || $fell(overflow)) |-> $past(err_clr));
endmodule

// File: rtl/pp_dreq_ctrl.sv
module pp_dreq_ctrl
  import pp_dreq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_tx,
  input  logic          dma_en,
  input  logic          thr_load,
  input  logic [CW-1:0] thr_value,
  input  logic [CW-1:0] level,
  output logic          dreq_n
);
  logic [CW-1:0] thr_q;
  logic [CW-1:0] metric;
  dir_e          dir_q;
  logic          armed_q;
  logic          req_q;
  logic          low;
  logic          hit;
  logic          dir_chg;

  // receive watches bytes held, transmit watches free slots
  assign metric  = dir_tx ? (CW'(DEPTH) - level) : level;
  assign low     = metric < CW'(LANES);
  assign hit     = (thr_q != '0) && (metric >= thr_q) && !low;
  assign dir_chg = dir_e'(dir_tx) != dir_q;
  assign dreq_n  = ~(req_q & dma_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      dir_q   <= DIR_RX;
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      if (thr_load) thr_q <= thr_value;
      dir_q <= dir_e'(dir_tx);
      if (!dma_en) begin
        armed_q <= 1'b1;
        req_q   <= 1'b0;
      end else if (dir_chg) begin
        armed_q <= 1'b0;
        req_q   <= 1'b0;
      end else if (req_q && low) begin
        armed_q <= 1'b0;
        req_q   <= 1'b0;
      end else if (!req_q && armed_q && hit) begin
        req_q <= 1'b1;
      end
    end
  end

  // R5
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ($past(armed_q) && $past(dma_en)));
  // R2
  zero_thr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ($past(thr_q) != '0));
  // R3
  hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && dma_en && !dir_chg && !low) |=> req_q);
  // R7
  dir_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && dir_chg) |=> !req_q);
  // R6
  en_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !req_q);
endmodule

// File: rtl/pp_fifo_dreq.sv
module pp_fifo_dreq
  import pp_dreq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HOST_BYTES = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = 8 * HOST_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dir,
  input  logic          cfg_dma_en,
  input  logic          thr_load,
  input  logic [CW-1:0] thr_value,
  input  logic          err_clr,
  input  logic          dev_in_valid,
  output logic          dev_in_ready,
  input  logic [7:0]    dev_in_data,
  output logic          dev_out_valid,
  input  logic          dev_out_ready,
  output logic [7:0]    dev_out_data,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic [CW-1:0] fill_level,
  output logic          underflow,
  output logic          overflow,
  output logic          dreq_n
);
  logic [CW-1:0] level;
  logic [CW-1:0] hp_pop;
  logic [CW-1:0] hp_push;
  byte_t         hp_data [HOST_BYTES];
  byte_t         peek [HOST_BYTES];
  byte_t         fifo_data [HOST_BYTES];
  logic [CW-1:0] fifo_push;
  logic [CW-1:0] fifo_pop;
  logic          dev_push;
  logic          dev_pop;

  assign dev_in_ready  = !cfg_dir && (level != CW'(DEPTH));
  assign dev_push      = dev_in_valid && dev_in_ready;
  assign dev_out_valid = cfg_dir && (level != '0);
  assign dev_out_data  = peek[0];
  assign dev_pop       = dev_out_valid && dev_out_ready;
  assign fill_level    = level;

  assign fifo_push = cfg_dir ? hp_push : CW'(dev_push);
  assign fifo_pop  = cfg_dir ? CW'(dev_pop) : hp_pop;

  for (genvar g = 0; g < HOST_BYTES; g++) begin : g_wsel
    if (g == 0) begin : g_first
      assign fifo_data[g] = cfg_dir ? hp_data[g] : dev_in_data;
    end else begin : g_rest
      assign fifo_data[g] = hp_data[g];
    end
  end

  pp_byte_fifo #(.DEPTH(DEPTH), .LANES(HOST_BYTES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (fifo_push),
    .push_data (fifo_data),
    .pop_cnt   (fifo_pop),
    .peek      (peek),
    .level     (level)
  );

  pp_host_port #(.DEPTH(DEPTH), .LANES(HOST_BYTES)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_tx     (cfg_dir),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .err_clr    (err_clr),
    .level      (level),
    .peek       (peek),
    .pop_cnt    (hp_pop),
    .push_cnt   (hp_push),
    .push_data  (hp_data),
    .host_rdata (host_rdata),
    .underflow  (underflow),
    .overflow   (overflow)
  );

  pp_dreq_ctrl #(.DEPTH(DEPTH), .LANES(HOST_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_tx    (cfg_dir),
    .dma_en    (cfg_dma_en),
    .thr_load  (thr_load),
    .thr_value (thr_value),
    .level     (level),
    .dreq_n    (dreq_n)
  );

  // R11
  stream_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_in_ready && dev_out_valid));
  // R6
  en_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |-> dreq_n);
endmodule

// File: tb/tb_pp_fifo_dreq.sv
`timescale 1ns/1ps
module tb_pp_fifo_dreq;
  logic clk = 1'b0;
  logic rst_n, cfg_dir, cfg_dma_en, thr_load, err_clr;
  logic [4:0] thr_value;
  logic dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [7:0] dev_in_data, dev_out_data;
  logic host_rd, host_wr;
  logic [15:0] host_wdata, host_rdata;
  logic [4:0] fill_level;
  logic underflow, overflow, dreq_n;

  int checks = 0;
  int fails = 0;
  int thr = 0;
  int lvl = 0;
  int wseq = 0;
  int rseq = 0;
  bit m_act, m_armed;

  always #2 clk = ~clk;

  pp_fifo_dreq dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_dma_en(cfg_dma_en),
    .thr_load(thr_load), .thr_value(thr_value), .err_clr(err_clr),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fill_level(fill_level), .underflow(underflow), .overflow(overflow), .dreq_n(dreq_n)
  );

  function automatic logic [7:0] pat(input int s);
    return 8'(s * 37 + 5);
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic dir);
    rst_n = 1'b0; cfg_dir = dir; cfg_dma_en = 1'b0; thr_load = 1'b0; thr_value = '0;
    err_clr = 1'b0; dev_in_valid = 1'b0; dev_in_data = '0; dev_out_ready = 1'b0;
    host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    lvl = 0; rseq = wseq; m_act = 1'b0; m_armed = 1'b1;
  endtask

  task automatic load_thr(input int t);
    thr_load = 1'b1; thr_value = 5'(t); thr = t;
    tick();
    thr_load = 1'b0;
  endtask

  // request model evaluated once per settled level
  task automatic model_eval(input int metric);
    if (m_act && metric < 2) begin
      m_act = 1'b0; m_armed = 1'b0;
    end else if (!m_act && m_armed && thr != 0 && metric >= thr && metric >= 2) begin
      m_act = 1'b1;
    end
  endtask

  task automatic set_en(input logic v);
    cfg_dma_en = v;
    tick();
    if (!v) begin m_act = 1'b0; m_armed = 1'b1; end
  endtask

  task automatic push_dev();
    dev_in_valid = 1'b1; dev_in_data = pat(wseq);
    tick();
    dev_in_valid = 1'b0;
    wseq++; lvl++;
  endtask

  task automatic host_read();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic host_write_pair();
    host_wr = 1'b1; host_wdata = {pat(wseq + 1), pat(wseq)};
    tick();
    host_wr = 1'b0;
  endtask

  task automatic check_req(input string rq, input int metric);
    tick();
    model_eval(metric);
    chk(rq, int'(dreq_n), m_act ? 0 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk("R1 dreq_n", int'(dreq_n), 1);
    chk("R1 fill_level", int'(fill_level), 0);
    chk("R1 flags", int'({underflow, overflow}), 0);
    chk("R1 dev_in_ready", int'(dev_in_ready), 1);
    chk("R1 dev_out_valid", int'(dev_out_valid), 0);

    // R2 R3 R5 R8 receive sweep over all thresholds
    for (int t = 0; t <= 16; t++) begin
      do_reset(1'b0);
      load_thr(t);
      set_en(1'b1);
      model_eval(0);
      chk("R2 R3 empty", int'(dreq_n), m_act ? 0 : 1);
      for (int k = 1; k <= 16; k++) begin
        push_dev();
        chk("R11 fill", int'(fill_level), lvl);
        check_req("R3 fill ramp", lvl);
      end
      chk("R11 full not ready", int'(dev_in_ready), 0);
      for (int k = 0; k < 8; k++) begin
        host_read();
        chk("R8 read word", int'(host_rdata), int'({pat(rseq + 1), pat(rseq)}));
        rseq += 2; lvl -= 2;
        check_req("R3 drain", lvl);
      end
      for (int k = 0; k < 4; k++) push_dev();
      check_req("R5 disarmed", lvl);
      set_en(1'b0);
      chk("R5 en low", int'(dreq_n), 1);
      set_en(1'b1);
      model_eval(lvl);
      chk("R5 rearm", int'(dreq_n), m_act ? 0 : 1);
    end

    // R4 R10 R11 R13 transmit sweep over all thresholds
    for (int t = 0; t <= 16; t++) begin
      do_reset(1'b1);
      load_thr(t);
      set_en(1'b1);
      model_eval(16);
      chk("R4 empty", int'(dreq_n), m_act ? 0 : 1);
      for (int k = 0; k < 8; k++) begin
        host_write_pair();
        wseq += 2; lvl += 2;
        chk("R10 fill", int'(fill_level), lvl);
        check_req("R4 fill ramp", 16 - lvl);
      end
      host_write_pair();
      chk("R10 overflow set", int'(overflow), 1);
      chk("R10 dropped", int'(fill_level), 16);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk("R13 cleared", int'({underflow, overflow}), 0);
      for (int k = 0; k < 16; k++) begin
        chk("R11 dev_out_valid", int'(dev_out_valid), 1);
        chk("R11 dev_out_data", int'(dev_out_data), int'(pat(rseq)));
        dev_out_ready = 1'b1; tick(); dev_out_ready = 1'b0;
        rseq++; lvl--;
        check_req("R4 drain", 16 - lvl);
      end
      chk("R11 empty not valid", int'(dev_out_valid), 0);
      set_en(1'b0);
      set_en(1'b1);
      model_eval(16);
      chk("R5 tx rearm", int'(dreq_n), m_act ? 0 : 1);
    end

    // R9 short reads
    do_reset(1'b0);
    for (int k = 0; k < 3; k++) push_dev();
    host_read();
    chk("R9 full read", int'(host_rdata), int'({pat(rseq + 1), pat(rseq)}));
    chk("R9 no underflow", int'(underflow), 0);
    host_read();
    chk("R9 one byte", int'(host_rdata), int'({8'h00, pat(rseq + 2)}));
    chk("R9 underflow", int'(underflow), 1);
    chk("R9 level", int'(fill_level), 0);
    host_read();
    chk("R9 empty read", int'(host_rdata), 0);
    tick();
    chk("R13 sticky", int'(underflow), 1);

    // R12 wrong-direction accesses
    host_wr = 1'b1; host_wdata = 16'hA55A; tick(); host_wr = 1'b0;
    chk("R12 rx write ignored", int'(fill_level), 0);
    do_reset(1'b1);
    host_write_pair(); wseq += 2;
    host_read();
    chk("R12 tx read zero", int'(host_rdata), 0);
    chk("R12 tx read no pop", int'(fill_level), 2);
    chk("R12 tx dev_in_ready", int'(dev_in_ready), 0);

    // R6 enable drop is immediate
    do_reset(1'b0);
    load_thr(4);
    set_en(1'b1);
    for (int k = 0; k < 4; k++) push_dev();
    tick();
    chk("R6 active", int'(dreq_n), 0);
    cfg_dma_en = 1'b0;
    #1;
    chk("R6 comb drop", int'(dreq_n), 1);
    tick();

    // R7 direction change
    do_reset(1'b0);
    load_thr(4);
    set_en(1'b1);
    for (int k = 0; k < 4; k++) push_dev();
    tick();
    chk("R7 active", int'(dreq_n), 0);
    cfg_dir = 1'b1;
    tick();
    chk("R7 cleared", int'(dreq_n), 1);
    repeat (2) tick();
    chk("R7 disarmed", int'(dreq_n), 1);
    set_en(1'b0);
    set_en(1'b1);
    chk("R7 rearm", int'(dreq_n), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule